// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block walks one DDR SDRAM rank from power-on to normal operation without software help. Once reset has been released and the clock is stable, a start pulse launches a fixed bring-up order on a command port. The order is: a 200 us settling wait, a precharge of all banks, and an extended mode register write that enables the DLL. Next comes a mode register write with the DLL-reset bit set, followed by a second 200 us quiet wait. After that come a second precharge-all, a configurable number of auto-refresh cycles, and a final mode register write without DLL reset. Every command is spaced from the next by its own minimum gap, counted in clocks.

After the final mode write the sequencer pulses a receive-FIFO pointer resync for one cycle. It then hands the command bus to the normal controller and finally raises its done flag. The done flag also serves as the enable for the periodic refresh scheduler. The 200 us waits scale with an input giving the number of clock cycles per microsecond. The CAS latency, burst length and burst type carried by the mode register writes come from configuration inputs.

Top module: `ddr_bringup_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a start pulse is sampled, the outputs hold their idle values: command NOP, bank 0, address 0, resync 0, bus handover 0, done 0.
- R2: The first command is a precharge-all (address bit 10 set, bank 0, all other address bits 0). It appears exactly WAIT_US*i_clk_per_us cycles after the clock edge that samples i_start.
- R3: Exactly T_RP cycles after that precharge, an extended mode register write is issued to bank 1 with address 0.
- R4: Exactly T_MRD cycles after the extended mode write, a mode register write is issued to bank 0. Its address carries the mode word with bit 8 (DLL reset) set.
- R5: After the DLL-reset mode write, no command is issued for WAIT_US*i_clk_per_us cycles. At exactly that distance a second precharge-all is issued.
- R6: Exactly T_RP cycles after the second precharge, the first of 2+i_extra_ref auto-refresh commands is issued (bank 0, address 0). Consecutive refreshes are exactly T_RFC cycles apart.
- R7: Exactly T_RFC cycles after the last refresh, a final mode register write is issued to bank 0 with bit 8 clear. The mode word layout is: address[2:0] = i_burst_len, address[3] = i_burst_ilv, address[6:4] = i_cas, all other bits 0.
- R8: Exactly T_MRD cycles after the final mode write, o_fifo_resync is high for exactly one cycle, during which the command is NOP.
- R9: o_ctrl_owns_bus rises in the cycle after the resync pulse, and o_done rises one cycle after that. Both stay high until reset.
- R10: The command code is {ras_n, cas_n, we_n}: NOP 3'b111, precharge 3'b010, auto-refresh 3'b001, mode or extended-mode write 3'b000. In every cycle that issues no command, the port drives NOP with bank 0 and address 0.
- R11: A start pulse during an active sequence, or after done, has no effect on the command schedule or on the outputs.
- R12: Reset asserted in the middle of a sequence brings all outputs back to the R1 idle values. A fresh start pulse is then needed before any command is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| i_start | input | 1 | Start pulse; only honoured while idle |
| i_clk_per_us | input | CPU_W | Clock cycles per microsecond, scales the 200 us waits |
| i_extra_ref | input | EXTRA_W | Refresh cycles beyond the mandatory two |
| i_cas | input | 3 | CAS latency code for the mode word |
| i_burst_len | input | 3 | Burst length code for the mode word |
| i_burst_ilv | input | 1 | Burst type: 1 interleaved, 0 sequential |
| o_cmd | output | 3 | Command {ras_n, cas_n, we_n} |
| o_bank | output | BANK_W | Bank address |
| o_addr | output | ADDR_W | Row/mode address bus |
| o_fifo_resync | output | 1 | One-cycle receive-FIFO pointer resync pulse |
| o_ctrl_owns_bus | output | 1 | Command bus handed to the normal controller |
| o_done | output | 1 | Initialization complete; enables periodic refresh |

## Verification
The assertions assume that the configuration inputs stay unchanged from the start pulse until done, that i_clk_per_us is at least 1, and that the spacing parameters are at least 1. Under those conditions they check the one-cycle resync pulse, the ordering and permanence of handover and done, and the legality and payloads of the command codes. The stimulus sets every configuration value before it pulses start and holds it for the whole run. Directed runs use the default of six extra refreshes and the minimum of zero. Seeded random runs draw i_clk_per_us from 1 to 3 and the extra count and mode fields across their ranges. Stray start pulses and a mid-sequence reset are injected at chosen cycles.

// File: rtl/ddrseq_pkg.sv
package ddrseq_pkg;

  // Command code {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_MODE  = 3'b000,
    CMD_REF   = 3'b001,
    CMD_PRE   = 3'b010,
    CMD_NOP   = 3'b111
  } ddr_cmd_e;

  // State names tell which action fires when the gap counter expires
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TO_PRE1,
    ST_TO_EMRS,
    ST_TO_MRS_DLL,
    ST_TO_PRE2,
    ST_TO_REF,
    ST_TO_MRS_FIN,
    ST_TO_RESYNC,
    ST_RESYNC,
    ST_HANDOVER,
    ST_DONE
  } seq_state_e;

  // Mode word field positions (decoded by the DRAM)
  localparam int BL_LSB   = 0;
  localparam int BT_BIT   = 3;
  localparam int CAS_LSB  = 4;
  localparam int DLL_BIT  = 8;
  localparam int A10_BIT  = 10;

endpackage

// File: rtl/ddrseq_rst_sync.sv
module ddrseq_rst_sync (
  input  logic clk,
  input  logic i_rst_n,
  output logic o_rst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge i_rst_n) begin
    if (!i_rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign o_rst_n = sync_q;
endmodule

// File: rtl/ddrseq_gap_cnt.sv
module ddrseq_gap_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_load,
  input  logic [CNT_W-1:0] i_load_val,
  output logic             o_zero
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // A load of L makes o_zero true L-1 cycles later, so the next
  // action lands exactly L edges after the loading edge.
  always_comb begin
    cnt_en = i_load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (i_load) begin
      cnt_d = i_load_val - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign o_zero = (cnt_q == '0);
endmodule

// File: rtl/ddrseq_mode_word.sv
module ddrseq_mode_word
  import ddrseq_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [2:0]        i_burst_len,
  input  logic              i_burst_ilv,
  input  logic [2:0]        i_cas,
  output logic [ADDR_W-1:0] o_word
);
  always_comb begin
    o_word                      = '0;
    o_word[BL_LSB +: 3]         = i_burst_len;
    o_word[BT_BIT]              = i_burst_ilv;
    o_word[CAS_LSB +: 3]        = i_cas;
  end
endmodule

// File: rtl/ddrseq_fsm.sv
module ddrseq_fsm
  import ddrseq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BANK_W  = 2,
  parameter int EXTRA_W = 4,
  parameter int CNT_W   = 16,
  parameter int T_RP    = 3,
  parameter int T_MRD   = 2,
  parameter int T_RFC   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               i_start,
  input  logic [CNT_W-1:0]   i_wait_cycles,
  input  logic [EXTRA_W-1:0] i_extra_ref,
  input  logic [ADDR_W-1:0]  i_mode,
  input  logic               i_gap_zero,
  output logic               o_load,
  output logic [CNT_W-1:0]   o_load_val,
  output logic [2:0]         o_cmd,
  output logic [BANK_W-1:0]  o_bank,
  output logic [ADDR_W-1:0]  o_addr,
  output logic               o_resync,
  output logic               o_own,
  output logic               o_done
);
  localparam int REFC_W = EXTRA_W + 1;
  localparam logic [ADDR_W-1:0] A10_MASK = ADDR_W'(1) << A10_BIT;
  localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_BIT;
  localparam logic [CNT_W-1:0]  LV_RP    = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0]  LV_MRD   = CNT_W'(T_MRD);
  localparam logic [CNT_W-1:0]  LV_RFC   = CNT_W'(T_RFC);

  seq_state_e          state_q, state_d;
  logic [2:0]          cmd_q, cmd_d;
  logic [BANK_W-1:0]   bank_q, bank_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                resync_q, resync_d;
  logic                own_q, own_d;
  logic                done_q, done_d;
  logic [REFC_W-1:0]   ref_q, ref_d;

  always_comb begin
    state_d    = state_q;
    cmd_d      = CMD_NOP;
    bank_d     = '0;
    addr_d     = '0;
    resync_d   = 1'b0;
    own_d      = own_q;
    done_d     = done_q;
    ref_d      = ref_q;
    o_load     = 1'b0;
    o_load_val = i_wait_cycles;
    unique case (state_q)
      ST_IDLE: begin
        if (i_start) begin
          o_load     = 1'b1;
          o_load_val = i_wait_cycles;
          state_d    = ST_TO_PRE1;
        end
      end
      ST_TO_PRE1: begin
        if (i_gap_zero) begin
          cmd_d      = CMD_PRE;
          addr_d     = A10_MASK;
          o_load     = 1'b1;
          o_load_val = LV_RP;
          state_d    = ST_TO_EMRS;
        end
      end
      ST_TO_EMRS: begin
        if (i_gap_zero) begin
          cmd_d      = CMD_MODE;
          bank_d     = BANK_W'(1);
          o_load     = 1'b1;
          o_load_val = LV_MRD;
          state_d    = ST_TO_MRS_DLL;
        end
      end
      ST_TO_MRS_DLL: begin
        if (i_gap_zero) begin
          cmd_d      = CMD_MODE;
          addr_d     = i_mode | DLL_MASK;
          o_load     = 1'b1;
          o_load_val = i_wait_cycles;
          state_d    = ST_TO_PRE2;
        end
      end
      ST_TO_PRE2: begin
        if (i_gap_zero) begin
          cmd_d      = CMD_PRE;
          addr_d     = A10_MASK;
          o_load     = 1'b1;
          o_load_val = LV_RP;
          ref_d      = REFC_W'(i_extra_ref) + REFC_W'(2);
          state_d    = ST_TO_REF;
        end
      end
      ST_TO_REF: begin
        if (i_gap_zero) begin
          cmd_d      = CMD_REF;
          o_load     = 1'b1;
          o_load_val = LV_RFC;
          ref_d      = ref_q - REFC_W'(1);
          if (ref_q == REFC_W'(1)) begin
            state_d = ST_TO_MRS_FIN;
          end
        end
      end
      ST_TO_MRS_FIN: begin
        if (i_gap_zero) begin
          cmd_d      = CMD_MODE;
          addr_d     = i_mode & ~DLL_MASK;
          o_load     = 1'b1;
          o_load_val = LV_MRD;
          state_d    = ST_TO_RESYNC;
        end
      end
      ST_TO_RESYNC: begin
        if (i_gap_zero) begin
          resync_d = 1'b1;
          state_d  = ST_RESYNC;
        end
      end
      ST_RESYNC: begin
        own_d   = 1'b1;
        state_d = ST_HANDOVER;
      end
      ST_HANDOVER: begin
        done_d  = 1'b1;
        state_d = ST_DONE;
      end
      default: begin
        state_d = ST_DONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cmd_q    <= CMD_NOP;
      bank_q   <= '0;
      addr_q   <= '0;
      resync_q <= 1'b0;
      own_q    <= 1'b0;
      done_q   <= 1'b0;
      ref_q    <= '0;
    end else begin
      state_q  <= state_d;
      cmd_q    <= cmd_d;
      bank_q   <= bank_d;
      addr_q   <= addr_d;
      resync_q <= resync_d;
      own_q    <= own_d;
      done_q   <= done_d;
      ref_q    <= ref_d;
    end
  end

  assign o_cmd    = cmd_q;
  assign o_bank   = bank_q;
  assign o_addr   = addr_q;
  assign o_resync = resync_q;
  assign o_own    = own_q;
  assign o_done   = done_q;
endmodule

// File: rtl/ddr_bringup_seq.sv
module ddr_bringup_seq #(
  parameter int ADDR_W  = 13,
  parameter int BANK_W  = 2,
  parameter int CPU_W   = 8,
  parameter int EXTRA_W = 4,
  parameter int WAIT_US = 200,
  parameter int T_RP    = 3,
  parameter int T_MRD   = 2,
  parameter int T_RFC   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               i_start,
  input  logic [CPU_W-1:0]   i_clk_per_us,
  input  logic [EXTRA_W-1:0] i_extra_ref,
  input  logic [2:0]         i_cas,
  input  logic [2:0]         i_burst_len,
  input  logic               i_burst_ilv,
  output logic [2:0]         o_cmd,
  output logic [BANK_W-1:0]  o_bank,
  output logic [ADDR_W-1:0]  o_addr,
  output logic               o_fifo_resync,
  output logic               o_ctrl_owns_bus,
  output logic               o_done
);
  localparam int MAX_WAIT = WAIT_US * ((1 << CPU_W) - 1);
  localparam int CNT_W    = $clog2(MAX_WAIT + T_RP + T_MRD + T_RFC + 1);

  logic              rst_sync_n;
  logic [CNT_W-1:0]  wait_cycles;
  logic [ADDR_W-1:0] mode_word;
  logic              gap_load;
  logic [CNT_W-1:0]  gap_load_val;
  logic              gap_zero;

  assign wait_cycles = CNT_W'(WAIT_US) * CNT_W'(i_clk_per_us);

  ddrseq_rst_sync u_rst_sync (
    .clk     (clk),
    .i_rst_n (rst_n),
    .o_rst_n (rst_sync_n)
  );

  ddrseq_mode_word #(.ADDR_W(ADDR_W)) u_mode_word (
    .i_burst_len (i_burst_len),
    .i_burst_ilv (i_burst_ilv),
    .i_cas       (i_cas),
    .o_word      (mode_word)
  );

  ddrseq_gap_cnt #(.CNT_W(CNT_W)) u_gap_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .i_load     (gap_load),
    .i_load_val (gap_load_val),
    .o_zero     (gap_zero)
  );

  ddrseq_fsm #(
    .ADDR_W  (ADDR_W),
    .BANK_W  (BANK_W),
    .EXTRA_W (EXTRA_W),
    .CNT_W   (CNT_W),
    .T_RP    (T_RP),
    .T_MRD   (T_MRD),
    .T_RFC   (T_RFC)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .i_start       (i_start),
    .i_wait_cycles (wait_cycles),
    .i_extra_ref   (i_extra_ref),
    .i_mode        (mode_word),
    .i_gap_zero    (gap_zero),
    .o_load        (gap_load),
    .o_load_val    (gap_load_val),
    .o_cmd         (o_cmd),
    .o_bank        (o_bank),
    .o_addr        (o_addr),
    .o_resync      (o_fifo_resync),
    .o_own         (o_ctrl_owns_bus),
    .o_done        (o_done)
  );
endmodule

// File: rtl/ddr_bringup_seq_chk.sv
module ddr_bringup_seq_chk
  import ddrseq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [BANK_W-1:0] bank,
  input logic [ADDR_W-1:0] addr,
  input logic              resync,
  input logic              own,
  input logic              done
);
  assert_resync_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !resync);

  assert_resync_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> (cmd == CMD_NOP) && !own);

  assert_own_after_resync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own) |-> $past(resync));

  assert_done_needs_own_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> own);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_own_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    own |=> own);

  assert_quiet_after_handover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    own |-> (cmd == CMD_NOP) && (bank == '0) && (addr == '0));

  assert_pre_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> addr[A10_BIT]);

  assert_ext_mode_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_MODE) && (bank == BANK_W'(1))) |-> (addr == '0));

  assert_cmd_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NOP) || (cmd == CMD_PRE) || (cmd == CMD_REF) || (cmd == CMD_MODE));
endmodule

bind ddr_bringup_seq ddr_bringup_seq_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .cmd    (o_cmd),
  .bank   (o_bank),
  .addr   (o_addr),
  .resync (o_fifo_resync),
  .own    (o_ctrl_owns_bus),
  .done   (o_done)
);

// File: tb/ddr_bringup_seq_tb.sv
module ddr_bringup_seq_tb;
  localparam int ADDR_W  = 13;
  localparam int BANK_W  = 2;
  localparam int CPU_W   = 8;
  localparam int EXTRA_W = 4;
  localparam int WAIT_US = 200;
  localparam int T_RP    = 3;
  localparam int T_MRD   = 2;
  localparam int T_RFC   = 10;

  localparam logic [2:0] C_NOP  = 3'b111;
  localparam logic [2:0] C_PRE  = 3'b010;
  localparam logic [2:0] C_REF  = 3'b001;
  localparam logic [2:0] C_MODE = 3'b000;

  logic               clk;
  logic               rst_n;
  logic               start;
  logic [CPU_W-1:0]   cpu;
  logic [EXTRA_W-1:0] extra;
  logic [2:0]         cas, bl;
  logic               ilv;
  logic [2:0]         cmd;
  logic [BANK_W-1:0]  bank;
  logic [ADDR_W-1:0]  addr;
  logic               resync, own, done;

  int n_chk = 0;
  int n_fail = 0;

  ddr_bringup_seq #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .CPU_W(CPU_W), .EXTRA_W(EXTRA_W),
    .WAIT_US(WAIT_US), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .i_start(start), .i_clk_per_us(cpu),
    .i_extra_ref(extra), .i_cas(cas), .i_burst_len(bl), .i_burst_ilv(ilv),
    .o_cmd(cmd), .o_bank(bank), .o_addr(addr), .o_fifo_resync(resync),
    .o_ctrl_owns_bus(own), .o_done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mode_word(input logic [2:0] b,
      input logic t, input logic [2:0] c, input logic dll);
    logic [ADDR_W-1:0] w;
    w = '0;
    w[2:0] = b;
    w[3]   = t;
    w[6:4] = c;
    w[8]   = dll;
    return w;
  endfunction

  function automatic logic [31:0] pack_bus();
    return {14'd0, cmd, bank, addr};
  endfunction

  function automatic logic [31:0] idle_bus();
    return {14'd0, C_NOP, 2'd0, 13'd0};
  endfunction

  task automatic check_idle_outputs(input string req, input string what);
    check(pack_bus() == idle_bus() && !resync && !own && !done, req, what,
          {pack_bus()[28:0], resync, own, done}, {idle_bus()[28:0], 3'b000});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    check_idle_outputs("R1", "outputs during reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // Runs one sequence; glitch_k pulses start at that sample, abort_k resets there.
  task automatic run_seq(input int c_pu, input int n_extra, input logic [2:0] c_cas,
      input logic [2:0] c_bl, input logic c_ilv, input int glitch_k, input int abort_k);
    int ev_t[24];
    logic [31:0] ev_v[24];
    string ev_r[24];
    int ne;
    int t;
    int t_rs;
    int w;
    int idle_err;
    int flag_err;
    logic [31:0] last_bad;
    ne = 0; idle_err = 0; flag_err = 0; last_bad = '0;
    w = WAIT_US * c_pu;
    cpu = CPU_W'(c_pu); extra = EXTRA_W'(n_extra); cas = c_cas; bl = c_bl; ilv = c_ilv;
    t = w;
    ev_t[ne] = t; ev_v[ne] = {14'd0, C_PRE, 2'd0, 13'h400}; ev_r[ne] = "R2"; ne++;
    t += T_RP;
    ev_t[ne] = t; ev_v[ne] = {14'd0, C_MODE, 2'd1, 13'h000}; ev_r[ne] = "R3"; ne++;
    t += T_MRD;
    ev_t[ne] = t; ev_v[ne] = {14'd0, C_MODE, 2'd0, mode_word(c_bl, c_ilv, c_cas, 1'b1)};
    ev_r[ne] = "R4"; ne++;
    t += w;
    ev_t[ne] = t; ev_v[ne] = {14'd0, C_PRE, 2'd0, 13'h400}; ev_r[ne] = "R5"; ne++;
    t += T_RP;
    for (int j = 0; j < 2 + n_extra; j++) begin
      if (j > 0) t += T_RFC;
      ev_t[ne] = t; ev_v[ne] = {14'd0, C_REF, 2'd0, 13'h000}; ev_r[ne] = "R6"; ne++;
    end
    t += T_RFC;
    ev_t[ne] = t; ev_v[ne] = {14'd0, C_MODE, 2'd0, mode_word(c_bl, c_ilv, c_cas, 1'b0)};
    ev_r[ne] = "R7"; ne++;
    t_rs = t + T_MRD;

    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= t_rs + 6; k++) begin
      bit hit;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      hit = 1'b0;
      for (int i = 0; i < ne; i++) begin
        if (ev_t[i] == k) begin
          hit = 1'b1;
          check(pack_bus() == ev_v[i], ev_r[i], "command/bank/address at scheduled cycle",
                pack_bus(), ev_v[i]);
        end
      end
      if (!hit && pack_bus() != idle_bus()) begin
        idle_err++;
        last_bad = pack_bus();
      end
      if (resync != (k == t_rs) || own != (k >= t_rs + 1) || done != (k >= t_rs + 2))
        flag_err++;
      if (k == t_rs)
        check(resync && !own && cmd == C_NOP, "R8", "resync pulse", {resync, own}, 2'b10);
      if (k == t_rs + 1)
        check(!resync && own && !done, "R9", "bus handover", {resync, own, done}, 3'b010);
      if (k == t_rs + 2)
        check(own && done, "R9", "done after handover", {own, done}, 2'b11);
      if (k == glitch_k) start = 1'b1;
      if (k == abort_k) begin
        rst_n = 1'b0;
        #1;
        check_idle_outputs("R12", "outputs right after mid-sequence reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        start = 1'b0;
        repeat (5) @(negedge clk);
        idle_err = 0;
        for (int q = 0; q < 3 * w; q++) begin
          @(negedge clk);
          if (pack_bus() != idle_bus() || resync || own || done) idle_err++;
        end
        check(idle_err == 0, "R12", "no command without new start after reset",
              idle_err, 0);
        return;
      end
    end
    check(idle_err == 0, "R5 R10", "NOP and zero bus in every non-command cycle",
          last_bad, idle_bus());
    check(flag_err == 0, "R9", "resync/handover/done never out of place", flag_err, 0);
  endtask

  task automatic start_after_done();
    int bad;
    bad = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int q = 0; q < 1000; q++) begin
      @(negedge clk);
      if (pack_bus() != idle_bus() || !done || !own || resync) bad++;
    end
    check(bad == 0, "R11", "start after done has no effect", bad, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; cpu = 8'd1; extra = '0;
    cas = 3'b010; bl = 3'b010; ilv = 1'b1;
    do_reset();
    // R1: idle without start
    repeat (40) @(negedge clk);
    check_idle_outputs("R1", "idle until start");

    // Default: six extra refreshes, stray start during the bring-up (R11)
    run_seq(1, 6, 3'b010, 3'b010, 1'b1, 200 + T_RP + 1, -1);
    start_after_done();
    do_reset();

    // Minimum refresh count, stray start inside the 200 us gap (R6, R11)
    run_seq(2, 0, 3'b110, 3'b011, 1'b0, 400 + T_RP + T_MRD + 100, -1);
    do_reset();

    // Reset in the middle of the sequence, then a full run (R12)
    run_seq(1, 3, 3'b010, 3'b010, 1'b1, -1, 200 + T_RP + T_MRD + 20);
    run_seq(1, 3, 3'b011, 3'b001, 1'b0, -1, -1);
    do_reset();

    // Seeded random configurations
    for (int r = 0; r < 3; r++) begin
      run_seq(1 + int'($urandom_range(2)), int'($urandom_range(6)),
              3'($urandom_range(7)), 3'($urandom_range(7)), 1'($urandom_range(1)),
              -1, -1);
      do_reset();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule